// File: doc/BRIEF.md
# Two-Input Packet Arbiter with Preferred Port

This block merges two packet streams into one output stream. Every beat carries a data word, a start-of-packet flag, an end-of-packet flag and a valid qualifier, and each input also raises a request line while it has a packet to send. At a packet boundary one input, chosen by a parameter, is preferred when both hold a valid start-of-packet beat. Once a packet has started, its input keeps the grant until that packet's qualified end-of-packet beat has been accepted. Packets from the two inputs are therefore never interleaved on the output.

An input sends a beat on a clock edge when its valid is high and its data-available line from the block is high. The non-granted input is held off by keeping its data-available line low. The output side is a registered stage with a single ready input. A bounded-wait counter keeps the lower-priority input from waiting forever: once it has watched a set number of packets go to the preferred input while its own start beat was pending, it wins the next boundary.

Top module: `pkt_bias_arb2`

## Requirements
- R1: While reset is high and on the first cycle after it, out_vld is 0. With no request pending, both in_dav bits are 0. The wait counter starts from zero.
- R2: At a boundary, an input is a candidate when its in_req, in_vld and in_sop are all 1. When both inputs are candidates, only the preferred input (index HI_IN) sees in_dav high, unless R6 applies. in_dav is never high on both inputs at once.
- R3: After a beat with sop and no eop is accepted from an input, in_dav stays low on the other input until that input's end-of-packet beat has been accepted. This holds even if the other input requests in the meantime. The grant moves on the cycle after that eop beat.
- R4: Output beats keep the data, sop and eop of their input beats. out_src gives the input index (0 or 1). Each input's beats come out in order, with none lost or repeated. The beats of one packet are contiguous on the output.
- R5: An eop flag presented while the owner's in_vld is 0 does not end ownership.
- R6: Each time the preferred input is granted at a boundary while the other input is a candidate, a counter increments. When it has reached WAIT_PKTS, the other input wins the next boundary at which it is a candidate. The counter clears whenever the other input is granted.
- R7: When the block is idle, a candidate's in_dav goes high in the same cycle. A new packet may start on the cycle right after an eop beat (same or other input), with no idle cycle in between.
- R8: While out_vld is 1 and out_rdy is 0, both in_dav bits are 0, and out_vld, out_sop, out_eop, out_src and out_data hold their values.
- R9: A beat accepted on an input at a clock edge appears on the output registers after that same edge. With out_rdy high and nothing accepted, out_vld drops to 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 2 | Per-input request, high while a packet is pending |
| in_vld | input | 2 | Per-input beat valid qualifier |
| in_sop | input | 2 | Per-input start-of-packet flag |
| in_eop | input | 2 | Per-input end-of-packet flag |
| in_data | input | 2*DATA_W | Input words, input 0 in the low DATA_W bits |
| in_dav | output | 2 | Per-input data-available; a beat moves when in_vld and in_dav are both high |
| out_vld | output | 1 | Output beat valid |
| out_sop | output | 1 | Output start-of-packet |
| out_eop | output | 1 | Output end-of-packet |
| out_src | output | 1 | Index of the input the output beat came from |
| out_data | output | DATA_W | Output word |
| out_rdy | input | 1 | Downstream ready; the output beat is taken when out_vld and out_rdy are high |

## Verification
The bench builds the block with DATA_W=16, HI_IN=1 and WAIT_PKTS=2. Making input 1 the preferred one exposes any priority hardwired to index 0. A wait limit of two takes the counter past a single flag bit, so the bench checks the exact sequence preferred, preferred, other when both inputs send back-to-back single-beat packets. The 16-bit word tags each beat with its input, packet number and beat number, so the scoreboard detects reordering, loss and interleaving under random gaps, random back-pressure and invalid eop flags.

// File: rtl/pba_pkg.sv
package pba_pkg;
  typedef enum logic {OWN_FREE = 1'b0, OWN_HELD = 1'b1} own_st_t;
endpackage

// File: rtl/pba_pick.sv
// Boundary choice between the two inputs, with a bounded-wait counter
module pba_pick #(
  parameter int HI_IN     = 0,
  parameter int WAIT_PKTS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cand,
  input  logic       bnd_take,
  input  logic       take_src,
  output logic       pick,
  output logic       pick_ok
);
  localparam int   CW = $clog2(WAIT_PKTS + 1);
  localparam logic HI = (HI_IN != 0) ? 1'b1 : 1'b0;
  localparam logic LO = ~HI;

  logic [CW-1:0] waited;
  logic          starve;

  assign starve = (waited >= CW'(WAIT_PKTS));

  always_comb begin
    pick_ok = |cand;
    if (cand[HI] && cand[LO]) pick = starve ? LO : HI;
    else if (cand[HI])        pick = HI;
    else                      pick = LO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waited <= '0;
    end else if (bnd_take) begin
      if (take_src == LO)             waited <= '0;
      else if (cand[LO] && !starve)   waited <= waited + 1'b1;
    end
  end
endmodule

// File: rtl/pba_owner.sv
// Ownership tracker: holds the grant from a start beat to a qualified end beat
module pba_owner
  import pba_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_eop,
  input  logic pick,
  input  logic pick_ok,
  output logic held,
  output logic sel,
  output logic sel_ok
);
  own_st_t st;
  logic    own;

  always_comb begin
    held   = (st == OWN_HELD);
    sel    = held ? own : pick;
    sel_ok = held | pick_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= OWN_FREE;
      own <= 1'b0;
    end else if (take) begin
      if (take_eop) begin
        st <= OWN_FREE;
      end else begin
        st  <= OWN_HELD;
        own <= sel;
      end
    end
  end
endmodule

// File: rtl/pba_outreg.sv
// Registered output stage with a single ready input
module pba_outreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              ld_sop,
  input  logic              ld_eop,
  input  logic              ld_src,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              out_rdy,
  output logic              room,
  output logic              out_vld,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_src,
  output logic [DATA_W-1:0] out_data
);
  assign room = !out_vld || out_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_sop  <= 1'b0;
      out_eop  <= 1'b0;
      out_src  <= 1'b0;
      out_data <= '0;
    end else if (room) begin
      out_vld <= load;
      if (load) begin
        out_sop  <= ld_sop;
        out_eop  <= ld_eop;
        out_src  <= ld_src;
        out_data <= ld_data;
      end
    end
  end
endmodule

// File: rtl/pkt_bias_arb2.sv
// Two-input packet arbiter with a preferred input
module pkt_bias_arb2 #(
  parameter int DATA_W    = 32,
  parameter int HI_IN     = 0,
  parameter int WAIT_PKTS = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          in_req,
  input  logic [1:0]          in_vld,
  input  logic [1:0]          in_sop,
  input  logic [1:0]          in_eop,
  input  logic [2*DATA_W-1:0] in_data,
  output logic [1:0]          in_dav,
  output logic                out_vld,
  output logic                out_sop,
  output logic                out_eop,
  output logic                out_src,
  output logic [DATA_W-1:0]   out_data,
  input  logic                out_rdy
);
  logic [1:0]        cand;
  logic              pick, pick_ok;
  logic              held, sel, sel_ok;
  logic              room, xfer, bnd_take;
  logic [DATA_W-1:0] sel_data;

  assign cand     = in_req & in_vld & in_sop;
  assign xfer     = room && sel_ok && in_vld[sel];
  assign bnd_take = xfer && !held;
  assign sel_data = sel ? in_data[2*DATA_W-1:DATA_W] : in_data[DATA_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_dav
    assign in_dav[g] = room && sel_ok && (sel == 1'(g));
  end

  pba_pick #(.HI_IN(HI_IN), .WAIT_PKTS(WAIT_PKTS)) u_pick (
    .clk(clk), .rst(rst), .cand(cand), .bnd_take(bnd_take),
    .take_src(sel), .pick(pick), .pick_ok(pick_ok)
  );

  pba_owner u_owner (
    .clk(clk), .rst(rst), .take(xfer), .take_eop(in_eop[sel]),
    .pick(pick), .pick_ok(pick_ok), .held(held), .sel(sel), .sel_ok(sel_ok)
  );

  pba_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .load(xfer), .ld_sop(in_sop[sel]), .ld_eop(in_eop[sel]),
    .ld_src(sel), .ld_data(sel_data), .out_rdy(out_rdy), .room(room),
    .out_vld(out_vld), .out_sop(out_sop), .out_eop(out_eop),
    .out_src(out_src), .out_data(out_data)
  );
endmodule

// File: rtl/pba_chk.sv
// Property checker bound to the arbiter top
module pba_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        in_vld,
  input logic [1:0]        in_sop,
  input logic [1:0]        in_eop,
  input logic [1:0]        in_dav,
  input logic              out_vld,
  input logic              out_rdy,
  input logic              out_sop,
  input logic              out_eop,
  input logic              out_src,
  input logic [DATA_W-1:0] out_data
);
  logic [1:0] hs;
  logic       hs_g;
  logic       in_open, in_g;
  logic       o_open, o_g;

  assign hs   = in_vld & in_dav;
  assign hs_g = hs[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_open <= 1'b0;
      in_g    <= 1'b0;
      o_open  <= 1'b0;
      o_g     <= 1'b0;
    end else begin
      if (|hs) begin
        in_open <= !in_eop[hs_g];
        in_g    <= hs_g;
      end
      if (out_vld && out_rdy) begin
        o_open <= !out_eop;
        o_g    <= out_src;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) $past(rst) |-> !out_vld);

  p_dav_single_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(in_dav));

  p_grant_held_r3: assert property (@(posedge clk) disable iff (rst)
    in_open |-> !in_dav[~in_g]);

  p_contig_out_r4: assert property (@(posedge clk) disable iff (rst)
    (out_vld && o_open) |-> (out_src == o_g) && !out_sop);

  p_first_is_sop_r7: assert property (@(posedge clk) disable iff (rst)
    ((|hs) && !in_open) |-> in_sop[hs_g]);

  p_stall_nodav_r8: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |-> (in_dav == 2'b00));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |=> out_vld && $stable(out_data) && $stable(out_src)
                              && $stable(out_sop) && $stable(out_eop));
endmodule

bind pkt_bias_arb2 pba_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_sop(in_sop), .in_eop(in_eop),
  .in_dav(in_dav), .out_vld(out_vld), .out_rdy(out_rdy), .out_sop(out_sop),
  .out_eop(out_eop), .out_src(out_src), .out_data(out_data)
);

// File: tb/pkt_bias_arb2_bench.sv
`timescale 1ns/1ps
module pkt_bias_arb2_bench;
  localparam int DW   = 16;
  localparam int HI   = 1;
  localparam int WAIT = 2;
  localparam int NPKT = 60;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    req = '0, vld = '0, sop = '0, eop = '0;
  logic [2*DW-1:0] idata = '0;
  logic          rdy = 1'b1;
  logic [1:0]    dav;
  logic          ovld, osop, oeop, osrc;
  logic [DW-1:0] odata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pkt_bias_arb2 #(.DATA_W(DW), .HI_IN(HI), .WAIT_PKTS(WAIT)) u_pkt_bias_arb2 (
    .clk(clk), .rst(rst), .in_req(req), .in_vld(vld), .in_sop(sop), .in_eop(eop),
    .in_data(idata), .in_dav(dav), .out_vld(ovld), .out_sop(osop), .out_eop(oeop),
    .out_src(osrc), .out_data(odata), .out_rdy(rdy)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic put(input int g, input logic r, input logic v, input logic s,
                     input logic e, input logic [DW-1:0] d);
    req[g] = r; vld[g] = v; sop[g] = s; eop[g] = e;
    idata[g*DW +: DW] = d;
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // expected grant when both inputs hold single-beat packets, from the wait count
  function automatic logic [1:0] want_both(input int waited);
    return (waited >= WAIT) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [DW-1:0] tag(input int g, input int pk, input int bt);
    return {g[0], pk[6:0], bt[7:0]};
  endfunction

  logic [DW+1:0] q0[$];
  logic [DW+1:0] q1[$];

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R4 watchdog expired act=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int waited;
    logic [DW+1:0] e;
    bit act[2];
    int len[2], bt[2], pk[2];
    bit hs[2];
    bit otake, o_open, o_cur;
    logic [DW+1:0] obeat;
    logic osrc_s;
    void'($urandom(32'd1234));

    // R1: reset state
    repeat (3) nxt();
    #1;
    chk("R1 out_vld in reset", 32'(ovld), 0);
    chk("R1 dav in reset", 32'(dav), 0);
    nxt(); rst = 1'b0;
    #1;
    chk("R1 out_vld after reset", 32'(ovld), 0);
    chk("R1 dav idle", 32'(dav), 0);

    // R2: both request at a boundary, preferred input wins
    nxt(); put(1, 1, 1, 1, 0, 16'hA000); put(0, 1, 1, 1, 0, 16'hB000); #1;
    chk("R2 both request", 32'(dav), 32'b10);
    nxt(); put(1, 1, 1, 0, 1, 16'hA001); #1;
    chk("R3 owner keeps grant", 32'(dav), 32'b10);
    chk("R9 first beat out", {ovld, osrc, osop, odata}, {1'b1, 1'b1, 1'b1, 16'hA000});
    nxt(); put(1, 0, 0, 0, 0, 16'h0); #1;
    chk("R2 other after eop", 32'(dav), 32'b01);
    chk("R4 eop beat out", {ovld, osrc, oeop, odata}, {1'b1, 1'b1, 1'b1, 16'hA001});
    nxt(); put(0, 1, 1, 0, 1, 16'hB001); #1;
    chk("R3 low owner keeps", 32'(dav), 32'b01);
    nxt(); put(0, 0, 0, 0, 0, 16'h0); #1;
    chk("R4 low eop out", {ovld, osrc, oeop, odata}, {1'b1, 1'b0, 1'b1, 16'hB001});
    chk("R7 idle no grant", 32'(dav), 0);

    // R3/R5: request mid-packet and unqualified eop
    nxt(); put(0, 1, 1, 1, 0, 16'hC000); #1;
    chk("R7 same-cycle grant", 32'(dav), 32'b01);
    nxt(); put(0, 1, 1, 0, 0, 16'hC001); put(1, 1, 1, 1, 0, 16'hE000); #1;
    chk("R3 mid-packet request", 32'(dav), 32'b01);
    nxt(); put(0, 1, 0, 0, 1, 16'hC0FF); #1;
    chk("R5 eop without valid", 32'(dav), 32'b01);
    nxt(); #1;
    chk("R5 ownership kept", 32'(dav), 32'b01);
    nxt(); put(0, 1, 1, 0, 1, 16'hC002); #1;
    chk("R3 owner eop", 32'(dav), 32'b01);
    nxt(); put(0, 0, 0, 0, 0, 16'h0); #1;
    chk("R3 switch after eop", 32'(dav), 32'b10);
    chk("R4 low tail out", {ovld, osrc, oeop, odata}, {1'b1, 1'b0, 1'b1, 16'hC002});
    nxt(); put(1, 1, 1, 0, 1, 16'hE001); #1;
    chk("R3 high continues", 32'(dav), 32'b10);
    nxt(); put(1, 0, 0, 0, 0, 16'h0); #1;

    // R6: bounded wait with back-to-back single-beat packets
    waited = 0;
    for (int k = 0; k < 4; k++) begin
      nxt();
      put(0, 1, 1, 1, 1, tag(0, k, 0));
      put(1, 1, 1, 1, 1, tag(1, k, 0));
      #1;
      chk("R6 wait-limited grant", 32'(dav), 32'(want_both(waited)));
      if (k > 0) chk("R7 no bubble", 32'(ovld), 1);
      if (want_both(waited) == 2'b01) waited = 0;
      else if (waited < WAIT) waited++;
    end
    nxt(); put(0, 0, 0, 0, 0, 16'h0); put(1, 0, 0, 0, 0, 16'h0); #1;

    // R7: same input, two packets back to back
    for (int k = 0; k < 4; k++) begin
      nxt();
      put(1, 1, 1, (k % 2) == 0, (k % 2) == 1, tag(1, 20 + k / 2, k % 2));
      #1;
      chk("R7 back-to-back grant", 32'(dav), 32'b10);
      if (k > 0) chk("R7 back-to-back out", {ovld, odata}, {1'b1, tag(1, 20 + (k - 1) / 2, (k - 1) % 2)});
    end
    nxt(); put(1, 0, 0, 0, 0, 16'h0); #1;
    chk("R7 last beat", {ovld, oeop, odata}, {1'b1, 1'b1, tag(1, 21, 1)});

    // R8: back-pressure
    nxt(); put(1, 1, 1, 1, 0, 16'hF000); rdy = 1'b1; #1;
    chk("R8 grant before stall", 32'(dav), 32'b10);
    nxt(); put(1, 1, 1, 0, 1, 16'hF001); rdy = 1'b0; #1;
    chk("R8 no dav in stall", 32'(dav), 0);
    chk("R8 beat shown", {ovld, odata}, {1'b1, 16'hF000});
    nxt(); #1;
    chk("R8 held in stall", {ovld, osop, osrc, odata}, {1'b1, 1'b1, 1'b1, 16'hF000});
    chk("R8 still no dav", 32'(dav), 0);
    nxt(); rdy = 1'b1; #1;
    chk("R8 released", 32'(dav), 32'b10);
    nxt(); put(1, 0, 0, 0, 0, 16'h0); #1;
    chk("R9 next beat", {ovld, oeop, odata}, {1'b1, 1'b1, 16'hF001});
    nxt(); #1;
    chk("R9 drains", 32'(ovld), 0);

    // R4: random traffic, gaps, back-pressure, invalid eop flags
    act = '{0, 0}; len = '{0, 0}; bt = '{0, 0}; pk = '{0, 0}; hs = '{0, 0};
    otake = 0; o_open = 0; o_cur = 0; obeat = '0; osrc_s = 0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      nxt();
      if (otake) begin
        if (o_open && osrc_s != o_cur) chk("R4 interleave", 32'(osrc_s), 32'(o_cur));
        if (!o_open && !obeat[DW+1]) chk("R4 packet starts with sop", 0, 1);
        o_open = !obeat[DW];
        o_cur  = osrc_s;
        if (osrc_s ? (q1.size() == 0) : (q0.size() == 0)) chk("R4 unexpected beat", 32'(obeat), 0);
        else begin
          e = osrc_s ? q1.pop_front() : q0.pop_front();
          chk("R4 beat content", 32'(obeat), 32'(e));
        end
      end
      for (int g = 0; g < 2; g++) begin
        if (hs[g]) begin
          e = {sop[g], eop[g], idata[g*DW +: DW]};
          if (g == 0) q0.push_back(e); else q1.push_back(e);
          bt[g]++;
          if (eop[g]) begin act[g] = 0; pk[g]++; end
        end
      end
      for (int g = 0; g < 2; g++) begin
        if (!act[g] && pk[g] < NPKT && ($urandom % 4) == 0) begin
          act[g] = 1; len[g] = 1 + ($urandom % 4); bt[g] = 0;
        end
        if (act[g]) begin
          if (($urandom % 4) != 0)
            put(g, 1, 1, bt[g] == 0, bt[g] == len[g] - 1, tag(g, pk[g], bt[g]));
          else
            put(g, 1, 0, 1'($urandom), 1'($urandom), 16'hDEAD);
        end else begin
          put(g, 0, 0, 1'($urandom), 1'($urandom), 16'h0);
        end
      end
      rdy = (pk[0] >= NPKT && pk[1] >= NPKT) ? 1'b1 : (($urandom % 4) != 0);
      #1;
      hs[0] = vld[0] && dav[0];
      hs[1] = vld[1] && dav[1];
      otake = ovld && rdy;
      obeat = {osop, oeop, odata};
      osrc_s = osrc;
      if (pk[0] >= NPKT && pk[1] >= NPKT && !hs[0] && !hs[1] && !ovld
          && q0.size() == 0 && q1.size() == 0) break;
    end
    chk("R4 all packets sent", 32'(pk[0] + pk[1]), 32'(2 * NPKT));
    chk("R4 nothing left", 32'(q0.size() + q1.size()), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule